// File: doc/BRIEF.md
# Selectable Test Data Pattern Generator

This block produces one data-bus-wide word per beat of memory test traffic. A three-bit code picks one of five patterns: a fixed pattern that flips between all-ones and all-zeros words, three pseudo-random binary sequences of degree 7, 15 and 31, and a single set bit that walks left one position per beat. The block is fully deterministic. A traffic engine therefore uses two copies. One copy supplies write data. The other is restarted from the same seed and regenerates the expected data that read responses are compared against.

The output word is always valid. `beat_take` acts as the consumer's ready: while it is low, the word is held and no generator moves, so the consumer may apply back-pressure for any number of cycles. Each edge on which `beat_take` is high consumes the current word, and the next word appears after that edge. `reseed` restarts every generator from `seed_in` on the next edge and wins over `beat_take`. All five generators step on every taken beat, whichever one is selected. `pat_sel` only chooses which one drives the output, and it does so combinationally.

Top module: `tpg_pattern_gen`

## Requirements
- R1: After reset, the degree-7, degree-15 and degree-31 generator states all hold the value 1. The fixed pattern is in its all-ones phase, and the walking bit sits at bit 0.
- R2: Code 0 outputs all-ones, then all-zeros, alternating on each taken beat. After reset or restart it starts with all-ones.
- R3: Code 1 outputs the degree-7 sequence (x^7+x^6+1). For a degree-D generator with tap T and state s, one step computes f = s[D-1] ^ s[T-1] and then sets s = {s[D-2:0], f}. Output word bit i is the f produced by step i, with bit 0 first. A taken beat advances the state by DATA_W steps.
- R4: Code 2 outputs the degree-15 sequence (x^15+x^14+1), built in the same way as in R3.
- R5: Code 3 outputs the degree-31 sequence (x^31+x^28+1), built in the same way as in R3.
- R6: Code 4 outputs a word with exactly one bit set. That bit moves one position toward the MSB on each taken beat and wraps from bit DATA_W-1 back to bit 0.
- R7: Codes 5, 6 and 7 output the fixed pattern of R2.
- R8: When `reseed` is high at an edge, each generator of degree D loads seed_in[D-1:0]. The fixed pattern returns to all-ones and the walking bit returns to bit 0. This happens even if `beat_take` is also high.
- R9: A seed whose low D bits are all zero loads the value 1 into that generator instead. No generator state is ever zero.
- R10: Every generator steps on every taken beat whatever the code. A change of `pat_sel` alone changes the output in the same cycle.
- R11: With `reseed` and `beat_take` low and `pat_sel` unchanged, the output holds its value across an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pat_sel | input | 3 | Pattern code 0..7 |
| seed_in | input | 32 | Restart seed for the pseudo-random generators |
| reseed | input | 1 | Restart all generators on the next edge |
| beat_take | input | 1 | Consumer takes the current word; generators step |
| beat_data | output | DATA_W | Current pattern word, always valid |

## Verification
The hardest situation to reach from the ports is showing that generators which are not selected keep stepping, and that a restart with the same seed reproduces the same word stream exactly. The stimulus advances several beats under one code, switches the code without taking a beat, and compares the result against a model that steps all five generators on every take. It then restarts with a zero seed and with `reseed` and `beat_take` high together, and replays a stretch of beats to show that the stream repeats. The walking bit is taken past DATA_W beats so that the wrap from the MSB to bit 0 is observed.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [2:0] {
    PAT_FIXED  = 3'd0,
    PAT_PRBS7  = 3'd1,
    PAT_PRBS15 = 3'd2,
    PAT_PRBS31 = 3'd3,
    PAT_WALK   = 3'd4
  } pat_code_e;

  localparam int NUM_PRBS = 3;
  localparam int SEED_W   = 32;

  function automatic int prbs_degree(input int k);
    case (k)
      0: return 7;
      1: return 15;
      default: return 31;
    endcase
  endfunction

  function automatic int prbs_tap(input int k);
    case (k)
      0: return 6;
      1: return 14;
      default: return 28;
    endcase
  endfunction
endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int DEG    = 7,
  parameter int TAP    = 6,
  parameter int DATA_W = 64,
  parameter int SEED_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEED_W-1:0] seed_in,
  input  logic              reseed,
  input  logic              take,
  output logic [DATA_W-1:0] word
);
  localparam logic [DEG-1:0] ONE = DEG'(1);

  logic [DEG-1:0] state_q;
  logic [DEG-1:0] run_state;
  logic [DEG-1:0] seed_lo;
  logic [DEG-1:0] seed_norm;
  logic           fb;

  assign seed_lo   = seed_in[DEG-1:0];
  assign seed_norm = (seed_lo == '0) ? ONE : seed_lo;

  always_comb begin
    run_state = state_q;
    word      = '0;
    fb        = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      fb        = run_state[DEG-1] ^ run_state[TAP-1];
      word[i]   = fb;
      run_state = {run_state[DEG-2:0], fb};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= ONE;
    else if (reseed) state_q <= seed_norm;
    else if (take)   state_q <= run_state;
  end

  // R9
  state_never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R11
  lfsr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !take) |=> $stable(state_q));
endmodule

// File: rtl/tpg_fixed.sv
module tpg_fixed #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              take,
  output logic [DATA_W-1:0] word
);
  logic low_phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      low_phase_q <= 1'b0;
    else if (reseed) low_phase_q <= 1'b0;
    else if (take)   low_phase_q <= ~low_phase_q;
  end

  assign word = low_phase_q ? '0 : '1;

  // R2
  fixed_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !reseed) |=> (word != $past(word)));
endmodule

// File: rtl/tpg_walk.sv
module tpg_walk #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reseed,
  input  logic              take,
  output logic [DATA_W-1:0] word
);
  localparam logic [DATA_W-1:0] START = DATA_W'(1);

  logic [DATA_W-1:0] walk_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      walk_q <= START;
    else if (reseed) walk_q <= START;
    else if (take)   walk_q <= {walk_q[DATA_W-2:0], walk_q[DATA_W-1]};
  end

  assign word = walk_q;

  // R6
  walk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(walk_q) == 1);

  // R8
  walk_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> (walk_q == START));
endmodule

// File: rtl/tpg_pattern_gen.sv
module tpg_pattern_gen #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        pat_sel,
  input  logic [31:0]       seed_in,
  input  logic              reseed,
  input  logic              beat_take,
  output logic [DATA_W-1:0] beat_data
);
  import tpg_pkg::*;

  logic [DATA_W-1:0] prbs_word [NUM_PRBS];
  logic [DATA_W-1:0] fixed_word;
  logic [DATA_W-1:0] walk_word;

  for (genvar k = 0; k < NUM_PRBS; k++) begin : g_prbs
    tpg_lfsr #(
      .DEG   (prbs_degree(k)),
      .TAP   (prbs_tap(k)),
      .DATA_W(DATA_W),
      .SEED_W(SEED_W)
    ) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .seed_in(seed_in),
      .reseed (reseed),
      .take   (beat_take),
      .word   (prbs_word[k])
    );
  end

  tpg_fixed #(.DATA_W(DATA_W)) u_fixed (
    .clk   (clk),
    .rst_n (rst_n),
    .reseed(reseed),
    .take  (beat_take),
    .word  (fixed_word)
  );

  tpg_walk #(.DATA_W(DATA_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .reseed(reseed),
    .take  (beat_take),
    .word  (walk_word)
  );

  always_comb begin
    case (pat_sel)
      PAT_PRBS7:  beat_data = prbs_word[0];
      PAT_PRBS15: beat_data = prbs_word[1];
      PAT_PRBS31: beat_data = prbs_word[2];
      PAT_WALK:   beat_data = walk_word;
      default:    beat_data = fixed_word;
    endcase
  end

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !beat_take) |=> (!$stable(pat_sel) || $stable(beat_data)));

  // R7
  high_code_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_sel > 3'd4) |-> (beat_data == '0 || beat_data == '1));
endmodule

// File: tb/tb_tpg_pattern_gen.sv
module tb_tpg_pattern_gen;
  localparam int W = 64;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   pat_sel = 3'd0;
  logic [31:0]  seed_in = 32'd0;
  logic         reseed = 1'b0;
  logic         beat_take = 1'b0;
  logic [W-1:0] beat_data;

  tpg_pattern_gen #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .seed_in(seed_in),
    .reseed(reseed), .beat_take(beat_take), .beat_data(beat_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [W-1:0] exp;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model of the requirements
  logic [30:0]  m_st [3];
  bit           m_low;
  logic [W-1:0] m_walk;

  function automatic int deg_of(int k);
    return (k == 0) ? 7 : (k == 1) ? 15 : 31;
  endfunction
  function automatic int tap_of(int k);
    return (k == 0) ? 6 : (k == 1) ? 14 : 28;
  endfunction

  function automatic logic [W-1:0] prbs_out(int k);
    logic [30:0] s = m_st[k];
    logic [W-1:0] w = '0;
    int d = deg_of(k);
    int t = tap_of(k);
    for (int i = 0; i < W; i++) begin
      logic f = s[d-1] ^ s[t-1];
      w[i] = f;
      s = ((s << 1) | 31'(f)) & ((31'(1) << d) - 31'(1) | (d == 31 ? 31'h7fffffff : 31'h0));
    end
    return w;
  endfunction

  function automatic logic [30:0] prbs_next(int k);
    logic [30:0] s = m_st[k];
    int d = deg_of(k);
    int t = tap_of(k);
    for (int i = 0; i < W; i++) begin
      logic f = s[d-1] ^ s[t-1];
      s = ((s << 1) | 31'(f)) & ((31'(1) << d) - 31'(1) | (d == 31 ? 31'h7fffffff : 31'h0));
    end
    return s;
  endfunction

  function automatic logic [W-1:0] model_word(logic [2:0] sel);
    case (sel)
      3'd1: return prbs_out(0);
      3'd2: return prbs_out(1);
      3'd3: return prbs_out(2);
      3'd4: return m_walk;
      default: return m_low ? '0 : '1;
    endcase
  endfunction

  task automatic model_restart(logic [31:0] sd);
    for (int k = 0; k < 3; k++) begin
      int d = deg_of(k);
      logic [30:0] lo = sd[30:0] & ((31'(1) << d) - 31'(1) | (d == 31 ? 31'h7fffffff : 31'h0));
      m_st[k] = (lo == 0) ? 31'd1 : lo;
    end
    m_low  = 0;
    m_walk = W'(1);
  endtask

  task automatic model_step();
    for (int k = 0; k < 3; k++) m_st[k] = prbs_next(k);
    m_low  = !m_low;
    m_walk = {m_walk[W-2:0], m_walk[W-1]};
  endtask

  // Driver: one cycle of stimulus, then push the expected word
  task automatic op(logic [2:0] sel, logic rs, logic tk, logic [31:0] sd, string tag);
    @(negedge clk);
    pat_sel = sel; reseed = rs; beat_take = tk; seed_in = sd;
    @(posedge clk);
    #1;
    if (rs) model_restart(sd);
    else if (tk) model_step();
    q.push_back('{exp: model_word(sel), tag: tag});
  endtask

  // Monitor: compare away from the edge
  initial begin
    forever begin
      item_t it;
      wait (q.size() != 0);
      #2;
      it = q.pop_front();
      checks++;
      if (beat_data !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, beat_data, it.exp);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_restart(32'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every generator, viewed by select only
    for (int s = 0; s < 5; s++) op(3'(s), 0, 0, 0, "R1 reset state");

    // R2: fixed alternation
    for (int i = 0; i < 4; i++) op(3'd0, 0, 1, 0, "R2 fixed alternation");
    // R11: hold without take
    op(3'd0, 0, 0, 0, "R11 hold fixed");
    op(3'd0, 0, 0, 0, "R11 hold fixed again");

    // R7: codes 5..7 give fixed pattern
    for (int s = 5; s < 8; s++) begin
      op(3'(s), 0, 1, 0, "R7 high code fixed");
    end

    // R3/R4/R5 from a nonzero seed
    op(3'd1, 1, 0, 32'h1234_5678, "R8 restart prbs7");
    for (int i = 0; i < 5; i++) op(3'd1, 0, 1, 0, "R3 prbs7 beats");
    op(3'd2, 0, 0, 0, "R10 switch to prbs15");
    for (int i = 0; i < 5; i++) op(3'd2, 0, 1, 0, "R4 prbs15 beats");
    op(3'd3, 0, 0, 0, "R10 switch to prbs31");
    for (int i = 0; i < 5; i++) op(3'd3, 0, 1, 0, "R5 prbs31 beats");
    op(3'd3, 0, 0, 0, "R11 hold prbs31");
    op(3'd4, 0, 0, 0, "R10 walk kept stepping");
    op(3'd0, 0, 0, 0, "R10 fixed kept stepping");

    // R9: zero seed and low-bits-zero seed
    op(3'd1, 1, 0, 32'h0000_0000, "R9 zero seed prbs7");
    op(3'd2, 0, 0, 0, "R9 zero seed prbs15");
    op(3'd3, 0, 0, 0, "R9 zero seed prbs31");
    op(3'd1, 1, 0, 32'hFFFF_FF80, "R9 low7 zero seed prbs7");
    op(3'd1, 0, 1, 0, "R9 after low-zero seed step");

    // R8: restart wins over take, and stream repeats
    for (int rep = 0; rep < 2; rep++) begin
      op(3'd3, 1, 1, 32'hCAFE_F00D, "R8 restart with take");
      for (int i = 0; i < 4; i++) op(3'd3, 0, 1, 0, "R8 replayed prbs31");
    end
    op(3'd0, 1, 1, 32'h1, "R8 fixed back to ones");

    // R6: walking bit including wrap
    op(3'd4, 1, 0, 0, "R6 walk start");
    for (int i = 0; i < W + 3; i++) op(3'd4, 0, 1, 0, "R6 walk rotate");
    op(3'd4, 0, 0, 0, "R11 hold walk");

    wait (q.size() == 0);
    #5;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule